// File: doc/BRIEF.md
# Multi-region address wrap stepper

This block advances a byte pointer that walks a shared packet SRAM. It takes the current address and a step size, and returns the next address. The SRAM holds three circular regions. The first is a user area, bounded by programmable start and end pointers. The second is a general-purpose area, which runs from address zero up to one below the receive-start pointer. The third is a receive area, which runs from the receive-start pointer to the last physical address.

When a step carries the pointer past the end of a region, the result folds back to that region's start. Any bytes that overshoot the end carry into the folded result. When several regions end at the same address, a fixed priority decides which fold is applied. Addresses that cross no region end, such as a separate accelerator window above the SRAM, advance linearly.

One instance serves one pointer. A copy engine uses one for its source pointer and one for its destination pointer, and gives both the same region settings. Requests enter on a valid/ready stream and results leave on a valid/ready stream, with one result per request, in order. A result can be held back: `in_ready` is high only when the output register is empty or is being drained in the same cycle. While a result waits with `out_ready` low, that result does not change. The region pointers are plain inputs and are sampled in the cycle a request is accepted.

Top module: `wrap_stepper`

## Requirements
- R1: If `in_addr <= ua_end < in_addr + in_step`, the result is `ua_start + (in_addr + in_step - ua_end - 1)` and `out_wrap` is 1.
- R2: If `in_addr <= rx_start-1 < in_addr + in_step`, with `rx_start-1` taken modulo 2^16, the result is `in_addr + in_step - rx_start` and `out_wrap` is 2.
- R3: If `in_addr <= LAST_ADDR < in_addr + in_step`, with `LAST_ADDR` defaulting to 16'h5FFF, the result is `rx_start + (in_addr + in_step - LAST_ADDR - 1)` and `out_wrap` is 3.
- R4: When a step crosses more than one region end, the user fold wins over the general-purpose fold, and the general-purpose fold wins over the receive fold.
- R5: When no region end is crossed, the result is `(in_addr + in_step) mod 2^16` and `out_wrap` is 0. A step of 0 returns `in_addr` unchanged.
- R6: A crossing is decided on the address before the increment. A pointer that already sits one past a region end steps linearly.
- R7: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr` and `out_wrap` hold steady.
- R8: While reset is asserted and directly after it, `out_valid` is low.
- R9: Each request accepted in a cycle appears on the output in the next cycle, in acceptance order, with no loss and no duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request is present |
| in_ready | output | 1 | Request can be accepted |
| in_addr | input | 16 | Current pointer address |
| in_step | input | 2 | Bytes to advance (0 to 3) |
| rx_start | input | 16 | Receive-area start; the general-purpose area ends one below it |
| ua_start | input | 16 | User-area start (the fold target) |
| ua_end | input | 16 | User-area last address |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer accepts the result |
| out_addr | output | 16 | Next address after any fold |
| out_wrap | output | 2 | Fold applied: 0 none, 1 user, 2 general, 3 receive |

## Verification
The bench sets up region ends that coincide pairwise and all three at once. A design with the priority order reversed would then fold to zero or to the receive start where it should fold to the user start.

Steps of two and three that straddle an end check that overshoot carries into the folded address. A design that dropped the carry would land exactly on the region start. Pointers placed one past an end check for an off-by-one compare, which would fold a step that should be linear.

Random back-pressure on `out_ready` checks for lost or repeated results. The bench also covers addresses in the accelerator window and at the top of the 16-bit range, where only linear stepping is correct.

// File: rtl/wrap_pkg.sv
package wrap_pkg;
  localparam int N_REGIONS = 3;
  localparam int CODE_W    = $clog2(N_REGIONS + 1);

  // Region index order is also fold priority: lower index wins.
  typedef enum logic [CODE_W-1:0] {
    WRAP_NONE = 2'd0,
    WRAP_USER = 2'd1,
    WRAP_GP   = 2'd2,
    WRAP_RX   = 2'd3
  } wrap_kind_e;
endpackage

// File: rtl/region_cross.sv
module region_cross #(
  parameter int AW     = 16,
  parameter int STEP_W = 2
) (
  input  logic [AW-1:0]     cur,
  input  logic [STEP_W-1:0] step,
  input  logic [AW-1:0]     end_addr,
  input  logic [AW-1:0]     target,
  output logic              hit,
  output logic [AW-1:0]     folded
);
  logic [AW:0] sum;
  logic [AW:0] lim;
  logic [AW:0] over;

  always_comb begin
    sum    = {1'b0, cur} + (AW+1)'(step);
    lim    = {1'b0, end_addr};
    // Crossing is judged on the pre-increment address.
    hit    = (cur <= end_addr) && (sum > lim);
    over   = sum - lim - (AW+1)'(1);
    folded = AW'({1'b0, target} + over);
  end
endmodule

// File: rtl/wrap_priority_mux.sv
module wrap_priority_mux
  import wrap_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [N_REGIONS-1:0]         hit,
  input  logic [N_REGIONS-1:0][AW-1:0] cand,
  input  logic [AW-1:0]                linear,
  output logic [AW-1:0]                sel,
  output logic [CODE_W-1:0]            code
);
  always_comb begin
    sel  = linear;
    code = WRAP_NONE;
    for (int k = N_REGIONS - 1; k >= 0; k--) begin
      if (hit[k]) begin
        sel  = cand[k];
        code = CODE_W'(k + 1);
      end
    end
  end
endmodule

// File: rtl/wrap_stream_stage.sv
module wrap_stream_stage #(
  parameter int W       = 18,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic         vld_q;
      logic [W-1:0] dat_q;

      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign out_data  = dat_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (in_valid) dat_q <= in_data;
        end
      end
    end else begin : g_pass
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/wrap_stepper.sv
module wrap_stepper
  import wrap_pkg::*;
#(
  parameter int            AW        = 16,
  parameter int            STEP_W    = 2,
  parameter logic [AW-1:0] LAST_ADDR = 'h5FFF,
  parameter bit            REG_OUT   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [AW-1:0]     in_addr,
  input  logic [STEP_W-1:0] in_step,
  input  logic [AW-1:0]     rx_start,
  input  logic [AW-1:0]     ua_start,
  input  logic [AW-1:0]     ua_end,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [AW-1:0]     out_addr,
  output logic [CODE_W-1:0] out_wrap
);
  localparam int DW = AW + CODE_W;

  logic [N_REGIONS-1:0][AW-1:0] end_arr;
  logic [N_REGIONS-1:0][AW-1:0] tgt_arr;
  logic [N_REGIONS-1:0][AW-1:0] fold_arr;
  logic [N_REGIONS-1:0]         hit_vec;
  logic [AW-1:0]                linear;
  logic [AW-1:0]                next_addr;
  logic [CODE_W-1:0]            next_code;

  always_comb begin
    end_arr[0] = ua_end;
    tgt_arr[0] = ua_start;
    end_arr[1] = rx_start - AW'(1);
    tgt_arr[1] = '0;
    end_arr[2] = LAST_ADDR;
    tgt_arr[2] = rx_start;
    linear     = in_addr + AW'(in_step);
  end

  for (genvar k = 0; k < N_REGIONS; k++) begin : g_region
    region_cross #(.AW(AW), .STEP_W(STEP_W)) u_cross (
      .cur     (in_addr),
      .step    (in_step),
      .end_addr(end_arr[k]),
      .target  (tgt_arr[k]),
      .hit     (hit_vec[k]),
      .folded  (fold_arr[k])
    );
  end

  wrap_priority_mux #(.AW(AW)) u_mux (
    .hit   (hit_vec),
    .cand  (fold_arr),
    .linear(linear),
    .sel   (next_addr),
    .code  (next_code)
  );

  wrap_stream_stage #(.W(DW), .REG_OUT(REG_OUT)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  ({next_code, next_addr}),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data ({out_wrap, out_addr})
  );
endmodule

// File: rtl/wrap_stepper_chk.sv
module wrap_stepper_chk #(
  parameter int            AW        = 16,
  parameter int            STEP_W    = 2,
  parameter logic [AW-1:0] LAST_ADDR = 'h5FFF,
  parameter bit            REG_OUT   = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [AW-1:0]     in_addr,
  input logic [STEP_W-1:0] in_step,
  input logic [AW-1:0]     rx_start,
  input logic [AW-1:0]     ua_start,
  input logic [AW-1:0]     ua_end,
  input logic              out_valid,
  input logic              out_ready,
  input logic [AW-1:0]     out_addr,
  input logic [1:0]        out_wrap
);
  logic          fire;
  logic [AW-1:0] gp_end;
  assign fire   = in_valid && in_ready;
  assign gp_end = rx_start - AW'(1);

  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready)); // R7

  generate
    if (REG_OUT) begin : g_seq
      AST_USER_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fire && in_step == STEP_W'(1) && in_addr == ua_end
        |=> out_wrap == 2'd1 && out_addr == $past(ua_start)); // R1

      AST_GP_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fire && in_step == STEP_W'(1) && in_addr == gp_end && in_addr != ua_end
        |=> out_wrap == 2'd2 && out_addr == '0); // R2

      AST_RX_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fire && in_step == STEP_W'(1) && in_addr == LAST_ADDR
        && in_addr != ua_end && in_addr != gp_end
        |=> out_wrap == 2'd3 && out_addr == $past(rx_start)); // R3

      AST_ZERO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fire && in_step == '0 |=> out_wrap == 2'd0 && out_addr == $past(in_addr)); // R5

      AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready
        |=> out_valid && $stable(out_addr) && $stable(out_wrap)); // R7

      AST_ACCEPT_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> out_valid); // R9
    end
  endgenerate
endmodule

bind wrap_stepper wrap_stepper_chk #(
  .AW(AW), .STEP_W(STEP_W), .LAST_ADDR(LAST_ADDR), .REG_OUT(REG_OUT)
) u_chk (.*);

// File: tb/tb_wrap_stepper.sv
module tb_wrap_stepper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_addr = '0;
  logic [1:0]  in_step = '0;
  logic [15:0] rx_start = 16'h3000;
  logic [15:0] ua_start = 16'h1000;
  logic [15:0] ua_end = 16'h10FF;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_addr;
  logic [1:0]  out_wrap;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit stim_tag_valid = 1'b0;
  string cur_tag = "R9";

  int    q_addr[$];
  int    q_code[$];
  string q_tag[$];

  localparam int LAST = 16'h5FFF;

  always #10 clk = ~clk;

  wrap_stepper dut (.*);

  // Behavioural model of the next address.
  function automatic void model(input int a, input int s, input int uas,
                                input int uae, input int rx,
                                output int nxt, output int code);
    int ends[3];
    int tgts[3];
    ends[0] = uae;  tgts[0] = uas;
    ends[1] = (rx + 65535) % 65536; tgts[1] = 0;
    ends[2] = LAST; tgts[2] = rx;
    nxt  = (a + s) % 65536;
    code = 0;
    for (int k = 0; k < 3; k++) begin
      if (a <= ends[k] && a + s > ends[k]) begin
        nxt  = (tgts[k] + a + s - ends[k] - 1) % 65536;
        code = k + 1;
        return;
      end
    end
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic send(input string tag, input int uas, input int uae,
                      input int rx, input int a, input int s);
    @(negedge clk);
    cur_tag  = tag;
    ua_start = uas[15:0];
    ua_end   = uae[15:0];
    rx_start = rx[15:0];
    in_addr  = a[15:0];
    in_step  = s[1:0];
    in_valid = 1'b1;
    #3;
    while (!in_ready) begin
      @(negedge clk);
      #3;
    end
  endtask

  // Reference comparison on every clock.
  bit          prev_stall = 1'b0;
  logic [15:0] prev_addr;
  logic [1:0]  prev_code;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      check(out_valid == (q_addr.size() > 0), "R9", "out_valid",
            int'(out_valid), int'(q_addr.size() > 0));
      check(in_ready == (!out_valid || out_ready), "R7", "in_ready",
            int'(in_ready), int'(!out_valid || out_ready));
      if (prev_stall)
        check(out_addr == prev_addr && out_wrap == prev_code, "R7",
              "held result", int'(out_addr), int'(prev_addr));
      prev_stall = out_valid && !out_ready;
      prev_addr  = out_addr;
      prev_code  = out_wrap;
      if (out_valid && out_ready && q_addr.size() > 0) begin
        int ea;
        int ec;
        string t;
        ea = q_addr.pop_front();
        ec = q_code.pop_front();
        t  = q_tag.pop_front();
        check(int'(out_addr) == ea, t, "out_addr", int'(out_addr), ea);
        check(int'(out_wrap) == ec, t, "out_wrap", int'(out_wrap), ec);
      end
      if (in_valid && in_ready) begin
        int na;
        int nc;
        model(int'(in_addr), int'(in_step), int'(ua_start), int'(ua_end),
              int'(rx_start), na, nc);
        q_addr.push_back(na);
        q_code.push_back(nc);
        q_tag.push_back(cur_tag);
      end
    end
  end

  // Consumer back-pressure.
  initial begin
    forever begin
      @(negedge clk);
      out_ready = ($urandom_range(0, 3) != 0);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #3;
    check(out_valid == 1'b0, "R8", "out_valid after reset", int'(out_valid), 0);

    // R1 user fold, with overshoot carried
    send("R1", 'h1000, 'h10FF, 'h3000, 'h10FF, 1);
    send("R1", 'h1000, 'h10FF, 'h3000, 'h10FE, 2);
    send("R1", 'h1000, 'h10FF, 'h3000, 'h10FF, 3);
    // R6 one past end steps linearly
    send("R6", 'h1000, 'h10FF, 'h3000, 'h1100, 1);
    send("R6", 'h1000, 'h10FF, 'h3000, 'h3000, 2);
    // R2 general-purpose fold to zero
    send("R2", 'h1000, 'h10FF, 'h3000, 'h2FFF, 1);
    send("R2", 'h1000, 'h10FF, 'h3000, 'h2FFE, 3);
    // R3 receive fold
    send("R3", 'h1000, 'h10FF, 'h3000, 'h5FFF, 1);
    send("R3", 'h1000, 'h10FF, 'h3000, 'h5FFE, 3);
    // R4 coincident ends
    send("R4", 'h1000, 'h2FFF, 'h3000, 'h2FFF, 1);
    send("R4", 'h1000, 'h5FFF, 'h3000, 'h5FFF, 2);
    send("R4", 'h1000, 'h10FF, 'h6000, 'h5FFF, 1);
    send("R4", 'h0200, 'h5FFF, 'h6000, 'h5FFE, 3);
    // R5 linear and zero step
    send("R5", 'h1000, 'h10FF, 'h3000, 'h7800, 1);
    send("R5", 'h1000, 'h10FF, 'h3000, 'h10FF, 0);
    send("R5", 'h1000, 'h10FF, 'h3000, 'hFFFF, 1);

    for (int i = 0; i < 3000; i++) begin
      int rx;
      int uas;
      int uae;
      int a;
      int pick;
      rx  = $urandom_range(1, 16'h6000);
      uas = $urandom_range(0, 16'h5FFF);
      uae = $urandom_range(0, 8) == 0 ? (rx + 65535) % 65536 :
            ($urandom_range(0, 8) == 0 ? LAST : $urandom_range(uas, 16'h5FFF));
      pick = $urandom_range(0, 4);
      case (pick)
        0: a = uae - $urandom_range(0, 3);
        1: a = rx - 1 - $urandom_range(0, 3);
        2: a = LAST - $urandom_range(0, 3);
        3: a = 16'h7800 + $urandom_range(0, 16'h0450);
        default: a = $urandom_range(0, 65535);
      endcase
      a = (a + 65536) % 65536;
      send("R9", uas, uae, rx, a, $urandom_range(0, 3));
    end

    @(negedge clk);
    in_valid = 1'b0;
    repeat (20) @(negedge clk);
    #4;
    check(q_addr.size() == 0, "R9", "results drained", q_addr.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule